// File: doc/BRIEF.md
# Clock Output Source Selector

This block routes one of four free-running clocks onto a single clock output. The four sources are an internal RC oscillator, a crystal oscillator, a watchdog oscillator and the main clock. Software picks a source by writing a 2-bit code into a selection register over a simple synchronous register port.

The written code is only held pending. It moves into the committed selection when the stored bit 0 of a second register, the update register, goes from 0 to 1. In practice software writes that bit to 0 and then to 1. Writing the select register on its own, or writing 1 while the bit already holds 1, leaves the output clock alone.

A committed change is carried out by a handover state machine in the bus domain. It first withdraws the request for the old source and waits until that source's gate has closed. Only then does it raise the request for the new source. Each source has its own gate: a two-flop synchronizer clocked on that source's falling edge, so a gate only opens or closes while its clock is low.

The update register has two states. UPD_LOW moves to UPD_HIGH on a write with bit 0 set, and that transition is the commit. UPD_HIGH returns to UPD_LOW on a write with bit 0 clear. The handover machine has three states:
- SW_IDLE moves to SW_DROP when the committed selection differs from the active source, and withdraws the old request.
- SW_DROP moves to SW_RAISE once the old gate's acknowledge reads 0. On that transition it raises the new request and records the new source as active.
- SW_RAISE returns to SW_IDLE once the new gate's acknowledge reads 1.

Top module: `clkout_src_mux`

## Requirements
- R1: After reset the select register reads 0, the update register reads 0, and the output follows source 0 (internal RC oscillator).
- R2: Address 0 is the select register. A read returns the 2-bit pending code in bits 1:0 and 0 in bits 31:2. Writes to bits 31:2 are ignored.
- R3: A write to the select register alone does not change the committed selection or the output clock.
- R4: A write to address 1 with bit 0 = 1, while the stored update bit is 0, commits the pending code. The output then follows the selected source: code 0 is the internal RC oscillator, 1 the crystal oscillator, 2 the watchdog oscillator and 3 the main clock.
- R5: Writing bit 0 = 1 to address 1 while the stored update bit is already 1 commits nothing.
- R6: Address 1 is the update register. It reads its stored bit in bit 0 and 0 in bits 31:1.
- R7: The output never produces a high or low phase shorter than half the period of the faster of the two clocks involved in a switch.
- R8: At no time is more than one source gate open.
- R9: The read data is 0 whenever read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Word address: 0 selects the select register, 1 the update register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| src_clk | input | 4 | Source clocks, index equals select code |
| clk_out | output | 1 | Selected clock output |

## Verification
The output period is measured after three kinds of stimulus:
- A select write with no toggle, which must leave the period unchanged.
- A 0-then-1 toggle, which must switch the period to the new source.
- A repeated write of 1, which must leave the period unchanged.

Because the four sources have distinct periods, a wrong route, an early commit or a missed commit each show up as a wrong period. Random sequences mix these three actions with random codes. The bench compares each result against a model of the stored update bit. All the while, every output phase is timed against the shortest half period to expose glitches.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int DATA_W  = 32;

    localparam logic ADDR_SEL = 1'b0;
    localparam logic ADDR_UPD = 1'b1;

    typedef enum logic [SEL_W-1:0] {
        SRC_RC   = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_WDOG = 2'd2,
        SRC_MAIN = 2'd3
    } src_e;

    typedef enum logic {
        UPD_LOW,
        UPD_HIGH
    } upd_state_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_DROP,
        SW_RAISE
    } sw_state_e;
endpackage

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [SW-1:0] pend_sel,
    output logic          upd_bit,
    output logic [SW-1:0] commit_sel
);
    upd_state_e upd_st, upd_nx;
    logic       commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_st <= UPD_LOW;
        else        upd_st <= upd_nx;
    end

    // next state and commit strobe: only a low-to-high move commits
    always_comb begin
        upd_nx = upd_st;
        commit = 1'b0;
        if (wr_en && addr == ADDR_UPD) begin
            unique case (upd_st)
                UPD_LOW: begin
                    if (wdata[0]) begin
                        upd_nx = UPD_HIGH;
                        commit = 1'b1;
                    end
                end
                UPD_HIGH: begin
                    if (!wdata[0]) upd_nx = UPD_LOW;
                end
            endcase
        end
    end

    // pending and committed selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_sel   <= SW'(SRC_RC);
            commit_sel <= SW'(SRC_RC);
        end else begin
            if (wr_en && addr == ADDR_SEL) pend_sel <= wdata[SW-1:0];
            if (commit) commit_sel <= pend_sel;
        end
    end

    assign upd_bit = (upd_st == UPD_HIGH);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_SEL) rdata[SW-1:0] = pend_sel;
            else                  rdata[0]      = upd_bit;
        end
    end
endmodule

// File: rtl/clkout_handover.sv
`timescale 1ns/1ps
module clkout_handover
    import clkout_pkg::*;
#(
    parameter int SW = SEL_W,
    localparam int NS = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] commit_sel,
    input  logic [NS-1:0] src_ack,
    output logic [NS-1:0] src_req
);
    sw_state_e     sw_st, sw_nx;
    logic [SW-1:0] act, act_nx;
    logic [NS-1:0] req_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_st <= SW_IDLE;
        else        sw_st <= sw_nx;
    end

    // next state and outputs
    always_comb begin
        sw_nx  = sw_st;
        act_nx = act;
        req_nx = src_req;
        unique case (sw_st)
            SW_IDLE: begin
                if (commit_sel != act) begin
                    req_nx[act] = 1'b0;
                    sw_nx       = SW_DROP;
                end
            end
            SW_DROP: begin
                if (!src_ack[act]) begin
                    req_nx[commit_sel] = 1'b1;
                    act_nx             = commit_sel;
                    sw_nx              = SW_RAISE;
                end
            end
            SW_RAISE: begin
                if (src_ack[act]) sw_nx = SW_IDLE;
            end
            default: sw_nx = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act     <= SW'(SRC_RC);
            src_req <= NS'(1) << SRC_RC;
        end else begin
            act     <= act_nx;
            src_req <= req_nx;
        end
    end
endmodule

// File: rtl/clkout_src_gate.sv
`timescale 1ns/1ps
module clkout_src_gate #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic en,
    output logic gated
);
    logic meta;

    // both stages on the falling edge: the gate moves only while src_clk is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            en   <= RST_VAL;
        end else begin
            meta <= req;
            en   <= meta;
        end
    end

    assign gated = src_clk & en;
endmodule

// File: rtl/clkout_sync2.sv
`timescale 1ns/1ps
module clkout_sync2 #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkout_src_mux.sv
`timescale 1ns/1ps
module clkout_src_mux
    import clkout_pkg::*;
(
    input  logic                  bus_clk,
    input  logic                  bus_rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [NUM_SRC-1:0]    src_clk,
    output logic                  clk_out
);
    localparam logic [NUM_SRC-1:0] RST_ONEHOT = NUM_SRC'(1) << SRC_RC;

    logic [SEL_W-1:0]   pend_sel;
    logic [SEL_W-1:0]   commit_sel;
    logic               upd_bit;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_ack;
    logic [NUM_SRC-1:0] src_gated;

    clkout_regs #(.DW(DATA_W), .SW(SEL_W)) regs_i (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .pend_sel   (pend_sel),
        .upd_bit    (upd_bit),
        .commit_sel (commit_sel)
    );

    clkout_handover #(.SW(SEL_W)) hand_i (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .commit_sel (commit_sel),
        .src_ack    (src_ack),
        .src_req    (src_req)
    );

    clkout_sync2 #(.W(NUM_SRC), .RST_VAL(RST_ONEHOT)) ack_i (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (src_en),
        .q     (src_ack)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        clkout_src_gate #(.RST_VAL(RST_ONEHOT[i])) gate_i (
            .src_clk (src_clk[i]),
            .rst_n   (bus_rst_n),
            .req     (src_req[i]),
            .en      (src_en[i]),
            .gated   (src_gated[i])
        );
    end

    assign clk_out = |src_gated;
endmodule

// File: rtl/clkout_src_mux_chk.sv
`timescale 1ns/1ps
module clkout_src_mux_chk
    import clkout_pkg::*;
(
    input logic                  bus_clk,
    input logic                  bus_rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic                  addr,
    input logic [DATA_W-1:0]     wdata,
    input logic [DATA_W-1:0]     rdata,
    input logic [SEL_W-1:0]      commit_sel,
    input logic                  upd_bit,
    input logic [NUM_SRC-1:0]    src_en
);
    a_r8_single_gate: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $onehot0(src_en));

    a_r3_sel_write_keeps: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && addr == ADDR_SEL) |=> $stable(commit_sel));

    a_r5_high_rewrite_keeps: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && addr == ADDR_UPD && upd_bit) |=> $stable(commit_sel));

    a_r4_commit_cause: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(commit_sel) |-> $past(wr_en && addr == ADDR_UPD && wdata[0] && !upd_bit));

    a_r2_sel_upper_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rd_en && addr == ADDR_SEL) |-> (rdata[DATA_W-1:SEL_W] == '0));

    a_r6_upd_upper_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rd_en && addr == ADDR_UPD) |-> (rdata[DATA_W-1:1] == '0));

    a_r9_idle_read_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !rd_en |-> (rdata == '0));
endmodule

bind clkout_src_mux clkout_src_mux_chk chk_i (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .commit_sel (commit_sel),
    .upd_bit    (upd_bit),
    .src_en     (src_en)
);

// File: tb/clkout_src_mux_tb_top.sv
`timescale 1ns/1ps
module clkout_src_mux_tb_top;
    logic        bus_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  src_clk = '0;
    logic        clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    int glitches = 0;
    logic mon_on = 1'b0;
    real  last_edge = 0.0;

    always #10 bus_clk = ~bus_clk;   // 50 MHz
    always #7  src_clk[0] = ~src_clk[0];
    always #11 src_clk[1] = ~src_clk[1];
    always #19 src_clk[2] = ~src_clk[2];
    always #5  src_clk[3] = ~src_clk[3];

    clkout_src_mux dut_i (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .src_clk   (src_clk),
        .clk_out   (clk_out)
    );

    function automatic real period_of(int s);
        case (s)
            0:       return 14.0;
            1:       return 22.0;
            2:       return 38.0;
            default: return 10.0;
        endcase
    endfunction

    // R7: every phase at least the shortest half period (5 ns)
    always @(clk_out) begin
        real w;
        w = $realtime - last_edge;
        if (mon_on && w < 4.9) glitches++;
        last_edge = $realtime;
    end

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_period(string req, real exp);
        real t0, per;
        @(posedge clk_out);
        t0 = $realtime;
        repeat (4) @(posedge clk_out);
        per = ($realtime - t0) / 4.0;
        n_checks++;
        if (per < exp - 0.6 || per > exp + 0.6) begin
            n_fail++;
            $display("FAIL %s: actual period %0.2f expected %0.2f", req, per, exp);
        end
    endtask

    task automatic bus_write(logic a, logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(logic a, output logic [31:0] d);
        @(negedge bus_clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge bus_clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge bus_clk);
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int model_commit, model_pend;
        logic model_upd;
        void'($urandom(32'd2024));

        repeat (5) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        mon_on = 1'b1;

        // R1 reset state
        bus_read(1'b0, rd); check_val("R1 select reset", rd, 32'h0);
        bus_read(1'b1, rd); check_val("R1 update reset", rd, 32'h0);
        check_period("R1 reset source", period_of(0));

        // R9 idle read
        #1 check_val("R9 idle rdata", rdata, 32'h0);

        // R3 select write alone
        bus_write(1'b0, 32'd3);
        settle();
        check_period("R3 no commit", period_of(0));
        bus_read(1'b0, rd); check_val("R2 readback", rd, 32'd3);

        // R4 commit from low
        bus_write(1'b1, 32'd1);
        settle();
        check_period("R4 commit main", period_of(3));
        bus_read(1'b1, rd); check_val("R6 update readback", rd, 32'd1);

        // R5 rewrite of 1 while high
        bus_write(1'b0, 32'd2);
        bus_write(1'b1, 32'd1);
        settle();
        check_period("R5 no recommit", period_of(3));

        // R4 proper toggle
        bus_write(1'b1, 32'd0);
        bus_write(1'b1, 32'd1);
        settle();
        check_period("R4 commit watchdog osc", period_of(2));

        // R2 reserved bits ignored
        bus_write(1'b0, 32'hFFFF_FFFD);
        bus_read(1'b0, rd); check_val("R2 reserved ignored", rd, 32'd1);
        // R6 upper bits of update register
        bus_write(1'b1, 32'hFFFF_FFFE);
        bus_read(1'b1, rd); check_val("R6 upper bits zero", rd, 32'd0);
        bus_write(1'b1, 32'hFFFF_FFFF);
        bus_read(1'b1, rd); check_val("R6 upper bits zero set", rd, 32'd1);
        settle();
        check_period("R4 commit crystal", period_of(1));

        // random sequences
        model_commit = 1; model_pend = 1; model_upd = 1'b1;
        for (int k = 0; k < 12; k++) begin
            int s, act;
            s   = int'($urandom_range(3, 0));
            act = int'($urandom_range(2, 0));
            bus_write(1'b0, 32'(s));
            model_pend = s;
            if (act == 1) begin
                bus_write(1'b1, 32'd0);
                bus_write(1'b1, 32'd1);
                model_commit = model_pend;
                model_upd = 1'b1;
            end else if (act == 2) begin
                bus_write(1'b1, 32'd1);
                if (!model_upd) model_commit = model_pend;
                model_upd = 1'b1;
            end
            settle();
            bus_read(1'b0, rd); check_val("R2 random readback", rd, 32'(model_pend));
            check_period("R4 random output", period_of(model_commit));
        end

        n_checks++;
        if (glitches != 0) begin
            n_fail++;
            $display("FAIL R7: actual %0d short phases expected 0", glitches);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule